// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Control Registers

This block holds the software-visible control registers of a bus-master storage DMA engine with several channels (two by default). Each channel owns 8 bytes of a small I/O window. The lower 4 bytes of a channel form a command/status slot. The upper 4 bytes hold a 32-bit descriptor-table pointer. The block decodes every access by offset and size and returns read data one cycle later. Status writes mix three kinds of bit: bits that are simply stored, event bits that are cleared by writing a one, and an engine-owned activity flag that writes cannot change.

The DMA engine receives each channel's command byte, a start/stop level and the descriptor pointer. It returns an activity level per channel, and interrupt and error pulses per channel that set the matching event bits in the status byte.

Access size encoding on `acc_size`: 2'b00 byte, 2'b01 16-bit, 2'b10 32-bit, 2'b11 reserved. Read data is right-justified on `rd_data`.

Top module: `dmactl_regfile`

## Requirements
- R1: After reset, every channel's command byte, status byte and descriptor pointer are zero, so `cmd_out`, `ch_start` and `desc_addr` are all zero.
- R2: A byte read of the command/status slot returns the command byte at slot offset 0 and the status byte at offset 2, zero-extended to 32 bits. Offsets 1 and 3 return 0x000000FF. `rd_valid` and `rd_data` present the result in the cycle after the access.
- R3: Any command/status slot access that is not a byte access is rejected. A read returns ones across the access width: 0x0000FFFF for 16-bit, and 0xFFFFFFFF for 32-bit or reserved size. A write leaves the command and status bytes unchanged.
- R4: A byte write at slot offset 0 stores the whole byte as the command. The byte appears on the channel's `cmd_out` lane, and its bit 0 drives `ch_start`.
- R5: A byte write at slot offset 2 loads status bits 6 and 5 from the written data. It forces status bits 7, 4 and 3 to zero.
- R6: Status bit 0 takes the channel's `eng_active` level one cycle later, and no status write changes it.
- R7: Status bits 2 (interrupt) and 1 (error) clear when a status write has a 1 in that bit position. A 0 in that position leaves the bit as it was.
- R8: A pulse on `evt_irq` sets status bit 2, and a pulse on `evt_err` sets status bit 1, at the next clock edge. When an event and a clearing write land in the same cycle, the bit ends up set.
- R9: Byte writes at slot offsets 1 and 3 change nothing.
- R10: The descriptor pointer sits at channel offset +4. A 32-bit write stores the data with bits 1:0 forced to zero, and a 32-bit read returns the stored value. The low two address bits are ignored for these accesses. Other sizes read as ones across their width and do not write.
- R11: Channel n occupies window offsets 8n to 8n+7. An access to one channel never changes another channel's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW (4) | Byte offset within the window |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 32 | Write data, right-justified |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| cmd_out | output | NCH*8 | Command byte per channel |
| ch_start | output | NCH | Start/stop level per channel (command bit 0) |
| desc_addr | output | NCH*32 | Descriptor-table pointer per channel |
| eng_active | input | NCH | Engine activity level per channel |
| evt_irq | input | NCH | Interrupt event pulse per channel |
| evt_err | input | NCH | Error event pulse per channel |

## Verification
The bench targets the status byte's mixed write behaviour. It writes all ones into the reserved bits, writes zeros over the event bits, and writes a one to a cleared bit in the same cycle as its event pulse. A design that treated the whole byte as plain storage, or let the clear win, would read back the wrong value. It also writes over an active flag, which must survive the write. It sends 16-bit, 32-bit and reserved-size accesses to the byte slot, and byte accesses to the pointer. A design that honoured the wrong size would return data where ones are expected, or change a register. Accesses to one channel are followed by reads of the other, which would expose a slip in the channel decode.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

   localparam int DATA_W     = 32;
   localparam int CH_BYTES   = 8;
   localparam int OFF_CMD    = 0;
   localparam int OFF_STS    = 2;
   localparam int STS_ACT    = 0;
   localparam int STS_ERR    = 1;
   localparam int STS_IRQ    = 2;

   function automatic logic [DATA_W-1:0] ones_for(acc_size_e s);
      case (s)
         SZ_BYTE: ones_for = 32'h0000_00FF;
         SZ_HALF: ones_for = 32'h0000_FFFF;
         default: ones_for = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode
   import dmactl_pkg::*;
#(
   parameter int NCH = 2,
   parameter int CW  = 1,
   parameter int AW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic            acc_write,
   input  logic [AW-1:0]   acc_addr,
   input  acc_size_e       acc_size,
   output logic            rd_en,
   output logic [CW-1:0]   ch_idx,
   output logic [NCH-1:0]  cmd_we,
   output logic [NCH-1:0]  sts_we,
   output logic [NCH-1:0]  adr_we
);

   logic wr_en;
   logic ptr_slot;
   logic [1:0] boff;
   logic is_byte;
   logic is_word;

   assign rd_en    = acc_valid & ~acc_write;
   assign wr_en    = acc_valid &  acc_write;
   assign ptr_slot = acc_addr[2];
   assign boff     = acc_addr[1:0];
   assign is_byte  = (acc_size == SZ_BYTE);
   assign is_word  = (acc_size == SZ_WORD);

   generate
      if (NCH > 1) begin : g_multi
         assign ch_idx = acc_addr[AW-1:3];
      end else begin : g_single
         assign ch_idx = '0;
      end
   endgenerate

   for (genvar i = 0; i < NCH; i++) begin : g_we
      logic hit;
      assign hit       = wr_en && (ch_idx == CW'(i));
      assign cmd_we[i] = hit && !ptr_slot && is_byte && (boff == 2'(OFF_CMD));
      assign sts_we[i] = hit && !ptr_slot && is_byte && (boff == 2'(OFF_STS));
      assign adr_we[i] = hit &&  ptr_slot && is_word;
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cmd_we, sts_we, adr_we}) <= 1);                       // R11
   AST_NO_WIDE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_size != SZ_BYTE) |-> ((cmd_we | sts_we) == '0));           // R3

endmodule

// File: rtl/dmactl_chan.sv
module dmactl_chan
   import dmactl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic              sts_we,
   input  logic              adr_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              eng_active,
   input  logic              evt_irq,
   input  logic              evt_err,
   output logic [7:0]        cmd_q,
   output logic [7:0]        sts_q,
   output logic [DATA_W-1:0] adr_q
);

   logic [7:0] sts_d;

   always_comb begin
      sts_d = sts_q;
      if (sts_we) begin
         sts_d[7]   = 1'b0;
         sts_d[6:5] = wdata[6:5];
         sts_d[4:3] = 2'b00;
         sts_d[STS_IRQ] = sts_q[STS_IRQ] & ~wdata[STS_IRQ];
         sts_d[STS_ERR] = sts_q[STS_ERR] & ~wdata[STS_ERR];
      end
      sts_d[STS_ACT] = eng_active;
      if (evt_irq) sts_d[STS_IRQ] = 1'b1;
      if (evt_err) sts_d[STS_ERR] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         sts_q <= '0;
         adr_q <= '0;
      end else begin
         if (cmd_we) cmd_q <= wdata[7:0];
         sts_q <= sts_d;
         if (adr_we) adr_q <= {wdata[DATA_W-1:2], 2'b00};
      end
   end

   AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_irq |=> sts_q[STS_IRQ]);                                      // R8
   AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err |=> sts_q[STS_ERR]);                                      // R8
   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && wdata[STS_IRQ] && !evt_irq) |=> !sts_q[STS_IRQ]);     // R7
   AST_ACT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sts_q[STS_ACT] == $past(eng_active)));                  // R6
   AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_we |=> $stable(cmd_q));                                      // R9
   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !adr_we |=> $stable(adr_q));                                      // R10

endmodule

// File: rtl/dmactl_regfile.sv
module dmactl_regfile
   import dmactl_pkg::*;
#(
   parameter int NCH      = 2,
   parameter bit READ_REG = 1'b1,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int AW = (NCH > 1) ? CW + 3 : 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_write,
   input  logic [AW-1:0]         acc_addr,
   input  logic [1:0]            acc_size,
   input  logic [DATA_W-1:0]     acc_wdata,
   output logic                  rd_valid,
   output logic [DATA_W-1:0]     rd_data,
   output logic [NCH*8-1:0]      cmd_out,
   output logic [NCH-1:0]        ch_start,
   output logic [NCH*DATA_W-1:0] desc_addr,
   input  logic [NCH-1:0]        eng_active,
   input  logic [NCH-1:0]        evt_irq,
   input  logic [NCH-1:0]        evt_err
);

   if (NCH < 1 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("dmactl_regfile: NCH must be a power of two");
   end

   acc_size_e         size_e;
   logic              rd_en;
   logic [CW-1:0]     ch_idx;
   logic [NCH-1:0]    cmd_we, sts_we, adr_we;
   logic [7:0]        cmd_q [NCH];
   logic [7:0]        sts_q [NCH];
   logic [DATA_W-1:0] adr_q [NCH];
   logic [DATA_W-1:0] rd_comb;

   assign size_e = acc_size_e'(acc_size);

   dmactl_decode #(.NCH(NCH), .CW(CW), .AW(AW)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_size  (size_e),
      .rd_en     (rd_en),
      .ch_idx    (ch_idx),
      .cmd_we    (cmd_we),
      .sts_we    (sts_we),
      .adr_we    (adr_we)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dmactl_chan u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .cmd_we     (cmd_we[i]),
         .sts_we     (sts_we[i]),
         .adr_we     (adr_we[i]),
         .wdata      (acc_wdata),
         .eng_active (eng_active[i]),
         .evt_irq    (evt_irq[i]),
         .evt_err    (evt_err[i]),
         .cmd_q      (cmd_q[i]),
         .sts_q      (sts_q[i]),
         .adr_q      (adr_q[i])
      );
      assign cmd_out[i*8 +: 8]           = cmd_q[i];
      assign ch_start[i]                 = cmd_q[i][0];
      assign desc_addr[i*DATA_W +: DATA_W] = adr_q[i];
   end

   always_comb begin
      rd_comb = '0;
      if (rd_en) begin
         if (!acc_addr[2]) begin
            if (size_e == SZ_BYTE) begin
               case (acc_addr[1:0])
                  2'(OFF_CMD): rd_comb = {24'h0, cmd_q[ch_idx]};
                  2'(OFF_STS): rd_comb = {24'h0, sts_q[ch_idx]};
                  default:     rd_comb = ones_for(SZ_BYTE);
               endcase
            end else begin
               rd_comb = ones_for(size_e);
            end
         end else if (size_e == SZ_WORD) begin
            rd_comb = adr_q[ch_idx];
         end else begin
            rd_comb = ones_for(size_e);
         end
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_valid <= 1'b0;
               rd_data  <= '0;
            end else begin
               rd_valid <= rd_en;
               rd_data  <= rd_comb;
            end
         end
         AST_RD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !acc_write) |=> rd_valid);                    // R2
         AST_WIDE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !acc_write && !acc_addr[2] && acc_size == 2'b01)
            |=> (rd_data == 32'h0000_FFFF));                            // R3
      end else begin : g_rd_comb
         assign rd_valid = rd_en;
         assign rd_data  = rd_comb;
      end
   endgenerate

endmodule

// File: tb/dmactl_regfile_tb.sv
module dmactl_regfile_tb;

   localparam int NCH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [3:0]  acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic [31:0] acc_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [15:0] cmd_out;
   logic [1:0]  ch_start;
   logic [63:0] desc_addr;
   logic [1:0]  eng_active = '0;
   logic [1:0]  evt_irq = '0;
   logic [1:0]  evt_err = '0;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   dmactl_regfile #(.NCH(NCH)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .cmd_out(cmd_out),
      .ch_start(ch_start), .desc_addr(desc_addr), .eng_active(eng_active),
      .evt_irq(evt_irq), .evt_err(evt_err)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one access, read expectations go to the scoreboard
   task automatic acc(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [31:0] exp, input string tag,
                      input logic [1:0] irq = 2'b00, input logic [1:0] err = 2'b00);
      @(negedge clk);
      if (!wr) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = d;
      evt_irq = irq; evt_err = err;
      @(posedge clk); #1;
      acc_valid = 1'b0; acc_write = 1'b0; evt_irq = '0; evt_err = '0;
   endtask

   task automatic pulse(input logic [1:0] irq, input logic [1:0] err);
      @(negedge clk);
      evt_irq = irq; evt_err = err;
      @(posedge clk); #1;
      evt_irq = '0; evt_err = '0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL unexpected read: actual %h expected none", rd_data);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {32'h0, rd_data}, {32'h0, e});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check("R1 cmd_out", {48'h0, cmd_out}, 64'h0);
      check("R1 ch_start", {62'h0, ch_start}, 64'h0);
      check("R1 desc_addr", desc_addr, 64'h0);
      acc(0, 4'h2, 2'b00, 0, 32'h00, "R1 status zero");
      acc(0, 4'h4, 2'b10, 0, 32'h0, "R1 pointer zero");
      // R4 command write
      acc(1, 4'h0, 2'b00, 32'h09, 0, "");
      check("R4 cmd_out lane", {56'h0, cmd_out[7:0]}, 64'h09);
      check("R4 ch_start", {62'h0, ch_start}, 64'h1);
      acc(0, 4'h0, 2'b00, 0, 32'h09, "R4 command readback");
      // R2 unused offsets
      acc(0, 4'h1, 2'b00, 0, 32'hFF, "R2 offset1");
      acc(0, 4'h3, 2'b00, 0, 32'hFF, "R2 offset3");
      // R9 writes to unused offsets
      acc(1, 4'h1, 2'b00, 32'h55, 0, "");
      acc(1, 4'h3, 2'b00, 32'h66, 0, "");
      acc(0, 4'h0, 2'b00, 0, 32'h09, "R9 command kept");
      acc(0, 4'h2, 2'b00, 0, 32'h00, "R9 status kept");
      // R3 wide accesses
      acc(1, 4'h0, 2'b01, 32'hFFFF, 0, "");
      acc(1, 4'h2, 2'b10, 32'hFFFF_FFFF, 0, "");
      acc(0, 4'h0, 2'b00, 0, 32'h09, "R3 wide write ignored cmd");
      acc(0, 4'h2, 2'b00, 0, 32'h00, "R3 wide write ignored sts");
      acc(0, 4'h0, 2'b01, 0, 32'h0000_FFFF, "R3 half read");
      acc(0, 4'h2, 2'b10, 0, 32'hFFFF_FFFF, "R3 word read");
      acc(0, 4'h0, 2'b11, 0, 32'hFFFF_FFFF, "R3 reserved size read");
      // R5 status stored/reserved bits
      acc(1, 4'h2, 2'b00, 32'hF8, 0, "");
      acc(0, 4'h2, 2'b00, 0, 32'h60, "R5 bits 6,5 kept, 7,4,3 zero");
      // R8 event set
      pulse(2'b01, 2'b01);
      acc(0, 4'h2, 2'b00, 0, 32'h66, "R8 events set");
      // R7 write-one-to-clear
      acc(1, 4'h2, 2'b00, 32'h04, 0, "");
      acc(0, 4'h2, 2'b00, 0, 32'h02, "R7 clear irq only");
      acc(1, 4'h2, 2'b00, 32'h02, 0, "");
      acc(0, 4'h2, 2'b00, 0, 32'h00, "R7 clear err");
      // R8 set beats clear
      acc(1, 4'h2, 2'b00, 32'h64, 0, "", 2'b01, 2'b00);
      acc(0, 4'h2, 2'b00, 0, 32'h64, "R8 set wins over clear");
      // R6 active flag
      @(negedge clk); eng_active = 2'b01;
      acc(0, 4'h2, 2'b00, 0, 32'h65, "R6 active visible");
      acc(1, 4'h2, 2'b00, 32'h00, 0, "");
      acc(0, 4'h2, 2'b00, 0, 32'h05, "R6 active survives write");
      @(negedge clk); eng_active = 2'b00;
      acc(0, 4'h2, 2'b00, 0, 32'h04, "R6 active drops");
      // R10 descriptor pointer
      acc(1, 4'h4, 2'b10, 32'h1234_5677, 0, "");
      acc(0, 4'h4, 2'b10, 0, 32'h1234_5674, "R10 pointer aligned");
      check("R10 desc_addr ch0", {32'h0, desc_addr[31:0]}, 64'h1234_5674);
      acc(1, 4'h4, 2'b00, 32'hAB, 0, "");
      acc(1, 4'h6, 2'b01, 32'hCDEF, 0, "");
      acc(0, 4'h5, 2'b10, 0, 32'h1234_5674, "R10 narrow writes ignored");
      acc(0, 4'h4, 2'b00, 0, 32'hFF, "R10 byte read ones");
      acc(0, 4'h6, 2'b01, 0, 32'hFFFF, "R10 half read ones");
      // R11 second channel
      acc(1, 4'h8, 2'b00, 32'h01, 0, "");
      check("R11 ch_start both", {62'h0, ch_start}, 64'h3);
      check("R11 cmd_out ch1", {56'h0, cmd_out[15:8]}, 64'h01);
      acc(0, 4'h8, 2'b00, 0, 32'h01, "R11 ch1 command");
      acc(0, 4'h0, 2'b00, 0, 32'h09, "R11 ch0 command kept");
      acc(1, 4'hC, 2'b10, 32'hA000_0003, 0, "");
      acc(0, 4'hC, 2'b10, 0, 32'hA000_0000, "R11 ch1 pointer");
      acc(0, 4'h4, 2'b10, 0, 32'h1234_5674, "R11 ch0 pointer kept");
      check("R11 desc_addr ch1", {32'h0, desc_addr[63:32]}, 64'hA000_0000);
      pulse(2'b10, 2'b00);
      acc(0, 4'hA, 2'b00, 0, 32'h04, "R11 ch1 event");
      acc(0, 4'h2, 2'b00, 0, 32'h04, "R11 ch0 status kept");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R2 missing reads: actual %0d pending expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule